// File: doc/BRIEF.md
# Two-Wire Serial Slave for a 64-Byte Register Space

This block sits between a two-wire serial bus (standard START/STOP framing, byte transfers with a ninth acknowledge clock, up to 400 kHz) and a 64-byte space of time, control and RAM registers. A master selects the device with its 7-bit bus address. It then either loads an internal byte pointer and writes a run of bytes, or reads a run of bytes from the pointer onwards. The pointer advances by itself after every byte and wraps around the end of the space. Both bus lines are synchronised and oversampled with the system clock. The slave pulls SDA low through an open-drain enable and never stretches SCL.

On the register side the block drives a single-cycle write strobe and a read request. Read data must come back the cycle after the request. Neither direction carries back-pressure: the bus cannot be paused, so the register side must take each write in the cycle it is presented and must honour the fixed read latency. Two plain control outputs serve an attached timekeeping core. The first is a hold level that freezes copying of live time into the user-visible time registers while the pointer sits on them. The second is a clear pulse that zeroes the sub-second register and restarts the prescaler whenever a time register is written. A power-good input aborts a transfer, clears the pointer and shuts the slave off the bus while it is low.

Top module: `twi_regfile_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0x68, sent as byte 0xD0 for a write or 0xD1 for a read. For any other address it drives no acknowledge and makes no register access until the next START.
- R2: The slave acknowledges its address, the word-address byte and each written data byte by holding SDA low through the ninth clock.
- R3: In a write, the low 6 bits of the word-address byte load the pointer, and the upper 2 bits are ignored. Each following data byte is presented once on the write port at the pointer address, and the pointer then advances by one, wrapping from 0x3F to 0x00.
- R4: A random read (word address written, repeated START, then 0xD1) returns bytes MSB first, starting at the loaded address and continuing at consecutive addresses.
- R5: A read started directly with 0xD1 after START returns data from the address the pointer already holds.
- R6: During a read the pointer advances only when the master acknowledges a byte. A not-acknowledge releases SDA and ends the read, leaving the pointer on the last byte sent.
- R7: time_hold is high while an addressed transfer is open and the pointer is in 0x00..0x07. It drops once the pointer moves to 0x08 or above, or once a STOP is seen.
- R8: A written byte whose address is in 0x00..0x07 raises sub_clr for one cycle, in the same cycle as its write strobe. A write to any other address does not raise it.
- R9: While pwr_ok is low, the pointer is held at 0x00, SDA is released, time_hold is low, and bus activity causes no acknowledge and no register access.
- R10: SDA is sampled on rising SCL edges, and the slave starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| pwr_ok | input | 1 | Supply in tolerance; low aborts and blocks access |
| reg_wr_valid | output | 1 | One-cycle write strobe, no ready |
| reg_wr_addr | output | 6 | Write address |
| reg_wr_data | output | 8 | Write data |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_addr | output | 6 | Read address |
| reg_rd_data | input | 8 | Read data, valid the cycle after reg_rd_req |
| time_hold | output | 1 | Freeze copying into the user time registers |
| sub_clr | output | 1 | Pulse: clear the sub-second register and the prescaler |

## Verification
A pointer that has drifted shows up at once as a wrong byte address on the write port, or as a wrong byte shifted out on the very next read. The bench compares every such byte against its own model of the space. A bit counter that is one off moves the acknowledge away from the ninth clock, so the master sees a missing acknowledge within one byte time. A session flag that does not clear leaves time_hold high after STOP. Power loss is checked by re-reading through the bus after recovery, which exposes whether the pointer was really cleared.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    LS_IDLE,
    LS_DEV,
    LS_DEV_ACK,
    LS_WORD,
    LS_WORD_ACK,
    LS_WDAT,
    LS_WDAT_ACK,
    LS_RDAT,
    LS_RACK
  } link_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = en & scl_lvl & ~scl_q;
  assign scl_fall = en & ~scl_lvl & scl_q;
  assign start_ev = en & scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = en & scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/twi_ptr_unit.sv
module twi_ptr_unit #(
  parameter int ADDR_W    = 6,
  parameter int TIME_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              ptr_inc,
  input  logic              sess_set,
  input  logic              stop_ev,
  output logic [ADDR_W-1:0] ptr,
  output logic              time_hold
);
  localparam logic [ADDR_W:0] TIME_LIM = (ADDR_W+1)'(TIME_REGS);

  logic sess;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      sess <= 1'b0;
    end else if (!pwr_ok) begin
      ptr  <= '0;
      sess <= 1'b0;
    end else begin
      if (ptr_load)     ptr <= load_val;
      else if (ptr_inc) ptr <= ptr + 1'b1;
      if (stop_ev)       sess <= 1'b0;
      else if (sess_set) sess <= 1'b1;
    end
  end

  assign time_hold = sess & ({1'b0, ptr} < TIME_LIM);

  // R9: power loss clears the pointer and the hold
  a_r9_pwr_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (ptr == '0) && !time_hold);

  // R7: a STOP releases the hold
  a_r7_stop_releases_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !time_hold);
endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
  import twi_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          TIME_REGS = 8,
  parameter logic [6:0]  DEV_ADDR  = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] ptr,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] load_val,
  output logic              ptr_inc,
  output logic              sess_set,
  output logic              sda_oe,
  output logic              reg_wr_valid,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic              reg_rd_req,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              sub_clr
);
  localparam logic [ADDR_W:0] TIME_LIM = (ADDR_W+1)'(TIME_REGS);
  localparam logic [3:0]      BITS     = 4'(BYTE_W);

  link_state_t       state;
  logic [3:0]        bitc;
  logic [BYTE_W-1:0] shreg, tx_sh, tx_buf;
  logic              is_read, rd_pend, got_ack;
  logic              rx_state, byte_in;

  assign rx_state = (state == LS_DEV) || (state == LS_WORD) || (state == LS_WDAT);
  assign byte_in  = scl_fall && (bitc == BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LS_IDLE; bitc <= '0; shreg <= '0; tx_sh <= '0; tx_buf <= '0;
      is_read <= 1'b0; rd_pend <= 1'b0; got_ack <= 1'b0; sda_oe <= 1'b0;
      ptr_load <= 1'b0; load_val <= '0; ptr_inc <= 1'b0; sess_set <= 1'b0;
      reg_wr_valid <= 1'b0; reg_wr_addr <= '0; reg_wr_data <= '0;
      reg_rd_req <= 1'b0; reg_rd_addr <= '0; sub_clr <= 1'b0;
    end else if (!pwr_ok) begin
      state <= LS_IDLE; bitc <= '0; got_ack <= 1'b0; rd_pend <= 1'b0;
      sda_oe <= 1'b0; ptr_load <= 1'b0; ptr_inc <= 1'b0; sess_set <= 1'b0;
      reg_wr_valid <= 1'b0; reg_rd_req <= 1'b0; sub_clr <= 1'b0;
    end else begin
      ptr_load     <= 1'b0;
      ptr_inc      <= 1'b0;
      sess_set     <= 1'b0;
      reg_wr_valid <= 1'b0;
      reg_rd_req   <= 1'b0;
      sub_clr      <= 1'b0;
      rd_pend      <= reg_rd_req;
      if (rd_pend) tx_buf <= reg_rd_data;

      if (start_ev) begin
        state   <= LS_DEV;
        bitc    <= '0;
        sda_oe  <= 1'b0;
        got_ack <= 1'b0;
      end else if (stop_ev) begin
        state  <= LS_IDLE;
        sda_oe <= 1'b0;
      end else begin
        if (rx_state && scl_rise && (bitc != BITS)) begin
          shreg <= {shreg[BYTE_W-2:0], sda_lvl};
          bitc  <= bitc + 1'b1;
        end
        case (state)
          LS_DEV: if (byte_in) begin
            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
              sda_oe   <= 1'b1;
              sess_set <= 1'b1;
              is_read  <= shreg[0];
              if (shreg[0]) begin
                reg_rd_req  <= 1'b1;
                reg_rd_addr <= ptr;
              end
              state <= LS_DEV_ACK;
            end else begin
              state <= LS_IDLE;
            end
          end
          LS_DEV_ACK: if (scl_fall) begin
            bitc <= '0;
            if (is_read) begin
              tx_sh  <= tx_buf;
              sda_oe <= ~tx_buf[BYTE_W-1];
              state  <= LS_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= LS_WORD;
            end
          end
          LS_WORD: if (byte_in) begin
            ptr_load <= 1'b1;
            load_val <= shreg[ADDR_W-1:0];
            sda_oe   <= 1'b1;
            state    <= LS_WORD_ACK;
          end
          LS_WORD_ACK, LS_WDAT_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            bitc   <= '0;
            state  <= LS_WDAT;
          end
          LS_WDAT: if (byte_in) begin
            reg_wr_valid <= 1'b1;
            reg_wr_addr  <= ptr;
            reg_wr_data  <= shreg;
            ptr_inc      <= 1'b1;
            sub_clr      <= ({1'b0, ptr} < TIME_LIM);
            sda_oe       <= 1'b1;
            state        <= LS_WDAT_ACK;
          end
          LS_RDAT: if (scl_fall) begin
            if (bitc == BITS - 4'd1) begin
              sda_oe <= 1'b0;
              state  <= LS_RACK;
            end else begin
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b1};
              sda_oe <= ~tx_sh[BYTE_W-2];
              bitc   <= bitc + 1'b1;
            end
          end
          LS_RACK: begin
            if (scl_rise) begin
              if (!sda_lvl) begin
                ptr_inc     <= 1'b1;
                reg_rd_req  <= 1'b1;
                reg_rd_addr <= ptr + 1'b1;
                got_ack     <= 1'b1;
              end else begin
                state <= LS_IDLE;
              end
            end else if (scl_fall && got_ack) begin
              got_ack <= 1'b0;
              tx_sh   <= tx_buf;
              sda_oe  <= ~tx_buf[BYTE_W-1];
              bitc    <= '0;
              state   <= LS_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the slave only begins pulling SDA while SCL is low
  a_r10_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R3: a write strobe is followed by the pointer stepping past it
  a_r3_write_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n || !pwr_ok)
    reg_wr_valid |=> ptr == ADDR_W'($past(reg_wr_addr) + 1'b1));

  // R3: the register port performs at most one operation per cycle
  a_r3_single_port_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_valid, reg_rd_req}));

  // R9: nothing reaches the register port while power is bad
  a_r9_no_access_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !reg_wr_valid && !reg_rd_req && !sda_oe);
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave #(
  parameter int         ADDR_W      = 6,
  parameter int         TIME_REGS   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pwr_ok,
  output logic              reg_wr_valid,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [7:0]        reg_wr_data,
  output logic              reg_rd_req,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [7:0]        reg_rd_data,
  output logic              time_hold,
  output logic              sub_clr
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic ptr_load, ptr_inc, sess_set;
  logic [ADDR_W-1:0] ptr, load_val;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(pwr_ok), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_ptr_unit #(.ADDR_W(ADDR_W), .TIME_REGS(TIME_REGS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ptr_load(ptr_load),
    .load_val(load_val), .ptr_inc(ptr_inc), .sess_set(sess_set),
    .stop_ev(stop_ev), .ptr(ptr), .time_hold(time_hold)
  );

  twi_link_fsm #(.ADDR_W(ADDR_W), .TIME_REGS(TIME_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .scl_lvl(scl_lvl),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .ptr(ptr),
    .ptr_load(ptr_load), .load_val(load_val), .ptr_inc(ptr_inc),
    .sess_set(sess_set), .sda_oe(sda_oe), .reg_wr_valid(reg_wr_valid),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_req(reg_rd_req), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .sub_clr(sub_clr)
  );
endmodule

// File: tb/twi_regfile_slave_tb.sv
module twi_regfile_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, pwr_ok = 1'b1;
  logic sda_i, sda_oe, reg_wr_valid, reg_rd_req, time_hold, sub_clr;
  logic [5:0] reg_wr_addr, reg_rd_addr;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int n_chk = 0, n_bad = 0, wr_cnt = 0, clr_cnt = 0, bad_drive = 0;
  logic oe_q = 1'b0;

  always #4 clk = ~clk;
  assign sda_i = m_sda & ~sda_oe;

  twi_regfile_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_i), .sda_oe(sda_oe),
    .pwr_ok(pwr_ok), .reg_wr_valid(reg_wr_valid), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_req(reg_rd_req),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .time_hold(time_hold), .sub_clr(sub_clr)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 5 + 1);
      reg_rd_data <= 8'h00;
    end else begin
      if (reg_wr_valid) begin mem[reg_wr_addr] <= reg_wr_data; wr_cnt <= wr_cnt + 1; end
      if (reg_rd_req) reg_rd_data <= mem[reg_rd_addr];
      if (sub_clr) clr_cnt <= clr_cnt + 1;
    end
    oe_q <= sda_oe;
    if (sda_oe && !oe_q && m_scl) bad_drive <= bad_drive + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hq(); m_scl = 1'b1; hq(); hq(); m_scl = 1'b0; hq();
    end
    m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); ack = ~sda_i; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic rx_byte(input bit give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); m_scl = 1'b1; hq(); d[i] = sda_i; hq(); m_scl = 1'b0;
    end
    hq(); m_sda = give_ack ? 1'b0 : 1'b1; hq(); m_scl = 1'b1; hq(); hq();
    m_scl = 1'b0; hq(); m_sda = 1'b1;
  endtask

  task automatic t_reset();
    check(!sda_oe && !time_hold && !reg_wr_valid && !sub_clr, "R9 reset idle outputs",
          {sda_oe, time_hold, reg_wr_valid, sub_clr}, 0);
  endtask

  task automatic t_write_seq();
    logic a; int c0 = clr_cnt;
    bus_start();
    tx_byte(8'hD0, a); check(a, "R1 R2 address ack", a, 1);
    tx_byte(8'h0A, a); check(a, "R2 word ack", a, 1);
    tx_byte(8'h5C, a); tx_byte(8'h93, a); tx_byte(8'hE7, a);
    check(a, "R2 data ack", a, 1);
    bus_stop();
    exp_mem[10] = 8'h5C; exp_mem[11] = 8'h93; exp_mem[12] = 8'hE7;
    for (int i = 10; i < 13; i++) check(mem[i] == exp_mem[i], "R3 sequential write", mem[i], exp_mem[i]);
    check(clr_cnt == c0, "R8 no clear above time regs", clr_cnt, c0);
  endtask

  task automatic t_random_read();
    logic a; logic [7:0] d;
    bus_start(); tx_byte(8'hD0, a); tx_byte(8'h0A, a);
    bus_start(); tx_byte(8'hD1, a); check(a, "R1 read address ack", a, 1);
    rx_byte(1, d); check(d == exp_mem[10], "R4 random read first", d, exp_mem[10]);
    rx_byte(1, d); check(d == exp_mem[11], "R4 random read second", d, exp_mem[11]);
    rx_byte(0, d); check(d == exp_mem[12], "R4 random read third", d, exp_mem[12]);
    hq(); check(!sda_oe, "R6 SDA released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    bus_start(); tx_byte(8'hD1, a);
    rx_byte(0, d); check(d == exp_mem[12], "R5 R6 current read at last byte", d, exp_mem[12]);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a; int w0 = wr_cnt;
    bus_start();
    tx_byte(8'hA0, a); check(!a, "R1 foreign address not acked", a, 0);
    tx_byte(8'h05, a); tx_byte(8'h77, a); check(!a, "R1 foreign data not acked", a, 0);
    bus_stop();
    check(wr_cnt == w0, "R1 no write for foreign address", wr_cnt, w0);
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d; int c0 = clr_cnt;
    bus_start(); tx_byte(8'hD0, a); tx_byte(8'hFF, a);
    tx_byte(8'h3C, a); tx_byte(8'hC4, a); bus_stop();
    exp_mem[63] = 8'h3C; exp_mem[0] = 8'hC4;
    check(mem[63] == 8'h3C, "R3 upper word bits ignored", mem[63], 8'h3C);
    check(mem[0] == 8'hC4, "R3 pointer wraps on write", mem[0], 8'hC4);
    check(clr_cnt == c0 + 1, "R8 clear on time reg write", clr_cnt, c0 + 1);
    bus_start(); tx_byte(8'hD0, a); tx_byte(8'h3F, a);
    bus_start(); tx_byte(8'hD1, a);
    rx_byte(1, d); rx_byte(0, d);
    check(d == exp_mem[0], "R6 pointer wraps on read ack", d, exp_mem[0]);
    bus_stop();
  endtask

  task automatic t_hold();
    logic a; int c0 = clr_cnt;
    bus_start(); tx_byte(8'hD0, a); tx_byte(8'h06, a);
    check(time_hold, "R7 hold on time pointer", time_hold, 1);
    tx_byte(8'hA1, a); tx_byte(8'hA2, a);
    exp_mem[6] = 8'hA1; exp_mem[7] = 8'hA2;
    check(!time_hold, "R7 hold drops past time regs", time_hold, 0);
    check(clr_cnt == c0 + 2, "R8 two clears", clr_cnt, c0 + 2);
    bus_start(); tx_byte(8'hD0, a); tx_byte(8'h02, a);
    check(time_hold, "R7 hold again", time_hold, 1);
    bus_stop(); hq();
    check(!time_hold, "R7 hold drops on stop", time_hold, 0);
  endtask

  task automatic t_power();
    logic a; logic [7:0] d; int w0;
    bus_start(); tx_byte(8'hD0, a); tx_byte(8'h03, a);
    check(time_hold, "R7 hold before power loss", time_hold, 1);
    m_sda = 1'b0; hq(); m_scl = 1'b1; hq();
    pwr_ok = 1'b0; hq();
    check(!sda_oe && !time_hold, "R9 released on power loss", {sda_oe, time_hold}, 0);
    m_scl = 1'b0; hq(); bus_stop();
    w0 = wr_cnt;
    bus_start(); tx_byte(8'hD0, a); check(!a, "R9 no ack unpowered", a, 0);
    tx_byte(8'h30, a); tx_byte(8'h55, a); bus_stop();
    check(wr_cnt == w0, "R9 no write unpowered", wr_cnt, w0);
    pwr_ok = 1'b1; hq();
    bus_start(); tx_byte(8'hD1, a);
    rx_byte(0, d); check(d == exp_mem[0], "R9 pointer cleared", d, exp_mem[0]);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'(i * 5 + 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_seq();
    t_random_read();
    t_current_read();
    t_wrong_addr();
    t_wrap();
    t_hold();
    t_power();
    check(bad_drive == 0, "R10 drive starts only with SCL low", bad_drive, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule